// File: doc/BRIEF.md
# PHY Control-Register Indirect Access Engine

This block is a bus-master sequencer that reaches the internal control registers of a serial PHY. Those registers are not directly addressable: the PHY exposes a small byte-addressed window plus a page register, and behind the window sits an indirect command/address/data triplet with a busy flag. The engine takes one request at a time. A request carries a 5-bit device number, a 16-bit internal register address, a direction and write data. The engine turns it into the full chain of window accesses and returns the read data with a one-cycle done pulse.

Every inner access costs two bus transfers. The first writes the page register and the second makes the windowed access. The chain itself polls the busy flag. While busy is set, polls are spaced by a programmable gap counter, nominally 5 µs at the chip clock. A poll-count limit ends the request with a timeout indication, so a stuck PHY never hangs the engine.

The state machine has five states. ST_IDLE waits for a request. ST_PAGE drives the page-select write. ST_WIN drives the windowed access. ST_GAP waits between polls. ST_DONE emits the done pulse. Its transitions are:
- ST_IDLE to ST_PAGE on an accepted request.
- ST_PAGE to ST_WIN when the page write completes.
- ST_WIN to ST_PAGE when a step finishes and more steps remain.
- ST_WIN to ST_GAP when a poll reads busy below the limit.
- ST_WIN to ST_DONE on the last step or when the poll limit is reached.
- ST_GAP to ST_PAGE when the gap counter expires.
- ST_DONE to ST_IDLE unconditionally.

Top module: `phy_cr_engine`

## Requirements
- R1: During and straight after reset, `idle` is 1 and `done`, `timeout` and `m_req` are 0.
- R2: Every windowed access is immediately preceded by a completed write to byte address 0x800. That write carries the page word `{dev[4:0], addr[15:9]}`, i.e. ((dev & 0x1F) << 7) | ((addr >> 9) & 0x7F). The windowed access follows it as the very next transfer.
- R3: A windowed access to internal address A uses byte address (A & 0x1FF) << 2. The indirect command register is at internal address 0x80A0, the address register at 0x80A1 and the data register at 0x80A2.
- R4: A read request performs these steps in order: poll the command register until bit 0 reads 0; write the target address to 0x80A1; write 0x0001 to 0x80A0; poll again until not busy; read 0x80A2.
- R5: A write request performs these steps in order: poll until not busy; write the target address to 0x80A1; write the data to 0x80A2; write 0x0003 to 0x80A0. It ends there, with no poll after the start write.
- R6: In the command register, bit 0 written as 1 starts an operation and reads as 1 while busy; bit 1 is 1 for a write and 0 for a read.
- R7: After a poll reads bit 0 as 1 (and the limit is not reached), `m_req` stays low for exactly `cfg_poll_gap`+1 cycles, then the poll is repeated, page write first.
- R8: When MAX_POLLS consecutive polls of one poll phase read busy, the request ends. No further bus transfer is made, `done` pulses with `timeout` = 1, and `rdata` is 0.
- R9: `done` is high for exactly one cycle per request. In that cycle `rdata` holds the value read from 0x80A2 for a read, or 0 for a write.
- R10: `req_start` is ignored while `idle` is 0: it changes neither the bus sequence nor the result of the request in progress.
- R11: While `m_req` is high and `m_ready` is low, `m_req`, `m_we`, `m_addr` and `m_wdata` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Request strobe, taken only while idle |
| req_dev | input | 5 | PHY device number |
| req_addr | input | 16 | Internal PHY register address |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_wdata | input | DW | Data for a write request |
| cfg_poll_gap | input | GAPW | Idle cycles between busy polls, minus one |
| idle | output | 1 | Engine can accept a request |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Qualifies `done`: busy never cleared |
| rdata | output | DW | Read result, valid with `done` |
| m_req | output | 1 | Bus transfer request |
| m_we | output | 1 | Bus write enable |
| m_addr | output | ABW | Bus byte address |
| m_wdata | output | DW | Bus write data |
| m_rdata | input | DW | Bus read data, valid with `m_ready` |
| m_ready | input | 1 | Bus transfer completes this cycle |

## Verification
The bench builds the engine with MAX_POLLS = 4 and the default 16-bit data and 12-bit byte address. This small limit lets the timeout and its one-poll-short neighbour be reached in a handful of cycles. The bench sweeps all 32 device numbers against boundary addresses (0x0000, 0x01FF, 0x0200, 0xFFFF and a mid value) in both directions. Each run varies the busy-poll counts, bus wait states and gap values 0, 3 and 6. The expected page words, window offsets, step traces and read data are worked out arithmetically in the bench.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;

    localparam int IAW  = 16;   // internal PHY register address width
    localparam int DEVW = 5;    // device number width kept in the page word

    localparam logic [IAW-1:0] CR_CMD  = 16'h80A0;
    localparam logic [IAW-1:0] CR_ADR  = 16'h80A1;
    localparam logic [IAW-1:0] CR_DAT  = 16'h80A2;

    localparam int CMD_GO_BIT  = 0;  // start on write, busy on read
    localparam int CMD_DIR_BIT = 1;  // 1 = write, 0 = read

    localparam logic [11:0] PAGE_BYTE_OFF = 12'h800;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PAGE,
        ST_WIN,
        ST_GAP,
        ST_DONE
    } eng_state_t;

    typedef enum logic [2:0] {
        SP_POLL_PRE,
        SP_SET_ADDR,
        SP_KICK_RD,
        SP_POLL_POST,
        SP_FETCH,
        SP_PUT_DATA,
        SP_KICK_WR
    } step_t;

endpackage

// File: rtl/phy_cr_window_map.sv
module phy_cr_window_map
    import phy_cr_pkg::*;
#(
    parameter int DW  = 16,
    parameter int ABW = 12
) (
    input  logic [DEVW-1:0] dev,
    input  logic [IAW-1:0]  iaddr,
    output logic [DW-1:0]   page_word,
    output logic [ABW-1:0]  win_off
);
    localparam int PAGE_W = DEVW + 7;
    localparam int OFF_W  = 11;

    logic [PAGE_W-1:0] page_raw;
    logic [OFF_W-1:0]  off_raw;

    always_comb begin
        page_raw  = {dev, iaddr[15:9]};
        off_raw   = {iaddr[8:0], 2'b00};
        page_word = DW'(page_raw);
        win_off   = ABW'(off_raw);
    end

endmodule

// File: rtl/phy_cr_step_decode.sv
module phy_cr_step_decode
    import phy_cr_pkg::*;
#(
    parameter int DW = 16
) (
    input  step_t          step,
    input  logic           is_write,
    input  logic [IAW-1:0] tgt_addr,
    input  logic [DW-1:0]  tgt_wdata,
    output logic [IAW-1:0] acc_iaddr,
    output logic           acc_we,
    output logic [DW-1:0]  acc_wdata,
    output logic           acc_poll,
    output logic           acc_last,
    output step_t          nxt_step
);
    logic [DW-1:0] kick_rd_word;
    logic [DW-1:0] kick_wr_word;

    always_comb begin
        kick_rd_word = '0;
        kick_rd_word[CMD_GO_BIT] = 1'b1;
        kick_wr_word = kick_rd_word;
        kick_wr_word[CMD_DIR_BIT] = 1'b1;
    end

    always_comb begin
        acc_iaddr = CR_CMD;
        acc_we    = 1'b0;
        acc_wdata = '0;
        acc_poll  = 1'b0;
        acc_last  = 1'b0;
        nxt_step  = SP_POLL_PRE;
        unique case (step)
            SP_POLL_PRE: begin
                acc_poll = 1'b1;
                nxt_step = SP_SET_ADDR;
            end
            SP_SET_ADDR: begin
                acc_iaddr = CR_ADR;
                acc_we    = 1'b1;
                acc_wdata = DW'(tgt_addr);
                nxt_step  = is_write ? SP_PUT_DATA : SP_KICK_RD;
            end
            SP_KICK_RD: begin
                acc_we    = 1'b1;
                acc_wdata = kick_rd_word;
                nxt_step  = SP_POLL_POST;
            end
            SP_POLL_POST: begin
                acc_poll = 1'b1;
                nxt_step = SP_FETCH;
            end
            SP_FETCH: begin
                acc_iaddr = CR_DAT;
                acc_last  = 1'b1;
            end
            SP_PUT_DATA: begin
                acc_iaddr = CR_DAT;
                acc_we    = 1'b1;
                acc_wdata = tgt_wdata;
                nxt_step  = SP_KICK_WR;
            end
            SP_KICK_WR: begin
                acc_we    = 1'b1;
                acc_wdata = kick_wr_word;
                acc_last  = 1'b1;
            end
            default: begin
                acc_last = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/phy_cr_gap_timer.sv
module phy_cr_gap_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/phy_cr_engine.sv
module phy_cr_engine
    import phy_cr_pkg::*;
#(
    parameter int DW        = 16,
    parameter int ABW       = 12,
    parameter int GAPW      = 16,
    parameter int MAX_POLLS = 1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_start,
    input  logic [4:0]      req_dev,
    input  logic [15:0]     req_addr,
    input  logic            req_write,
    input  logic [DW-1:0]   req_wdata,
    input  logic [GAPW-1:0] cfg_poll_gap,
    output logic            idle,
    output logic            done,
    output logic            timeout,
    output logic [DW-1:0]   rdata,
    output logic            m_req,
    output logic            m_we,
    output logic [ABW-1:0]  m_addr,
    output logic [DW-1:0]   m_wdata,
    input  logic [DW-1:0]   m_rdata,
    input  logic            m_ready
);
    localparam int PCW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
    localparam logic [PCW-1:0] POLL_LAST = PCW'(MAX_POLLS - 1);
    localparam logic [ABW-1:0] PAGE_ADDR = ABW'(PAGE_BYTE_OFF);

    eng_state_t state_q, state_d;
    step_t      step_q;

    logic [DEVW-1:0] dev_q;
    logic [IAW-1:0]  addr_q;
    logic            wr_q;
    logic [DW-1:0]   wdata_q;
    logic [DW-1:0]   rdata_q;
    logic [PCW-1:0]  poll_cnt_q;
    logic            timeout_q;

    logic [IAW-1:0]  acc_iaddr;
    logic            acc_we;
    logic [DW-1:0]   acc_wdata;
    logic            acc_poll;
    logic            acc_last;
    step_t           nxt_step;

    logic [DW-1:0]   page_word;
    logic [ABW-1:0]  win_off;

    logic xfer;
    logic win_done;
    logic busy_seen;
    logic at_limit;
    logic gap_load;
    logic gap_expired;

    phy_cr_step_decode #(.DW(DW)) u_step (
        .step      (step_q),
        .is_write  (wr_q),
        .tgt_addr  (addr_q),
        .tgt_wdata (wdata_q),
        .acc_iaddr (acc_iaddr),
        .acc_we    (acc_we),
        .acc_wdata (acc_wdata),
        .acc_poll  (acc_poll),
        .acc_last  (acc_last),
        .nxt_step  (nxt_step)
    );

    phy_cr_window_map #(.DW(DW), .ABW(ABW)) u_map (
        .dev       (dev_q),
        .iaddr     (acc_iaddr),
        .page_word (page_word),
        .win_off   (win_off)
    );

    phy_cr_gap_timer #(.CW(GAPW)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (cfg_poll_gap),
        .expired  (gap_expired)
    );

    always_comb begin
        xfer      = m_req & m_ready;
        win_done  = (state_q == ST_WIN) & xfer;
        busy_seen = win_done & acc_poll & m_rdata[CMD_GO_BIT];
        at_limit  = (poll_cnt_q == POLL_LAST);
        gap_load  = busy_seen & ~at_limit;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_start) state_d = ST_PAGE;
            ST_PAGE: if (xfer) state_d = ST_WIN;
            ST_WIN: begin
                if (xfer) begin
                    if (busy_seen) begin
                        state_d = at_limit ? ST_DONE : ST_GAP;
                    end else if (acc_last) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d = ST_PAGE;
                    end
                end
            end
            ST_GAP:  if (gap_expired) state_d = ST_PAGE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // request context, step and poll bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q     <= SP_POLL_PRE;
            dev_q      <= '0;
            addr_q     <= '0;
            wr_q       <= 1'b0;
            wdata_q    <= '0;
            rdata_q    <= '0;
            poll_cnt_q <= '0;
            timeout_q  <= 1'b0;
        end else begin
            if ((state_q == ST_IDLE) && req_start) begin
                step_q     <= SP_POLL_PRE;
                dev_q      <= req_dev;
                addr_q     <= req_addr;
                wr_q       <= req_write;
                wdata_q    <= req_wdata;
                rdata_q    <= '0;
                poll_cnt_q <= '0;
                timeout_q  <= 1'b0;
            end
            if (win_done) begin
                if (busy_seen) begin
                    poll_cnt_q <= poll_cnt_q + 1'b1;
                    if (at_limit) timeout_q <= 1'b1;
                end else begin
                    step_q     <= nxt_step;
                    poll_cnt_q <= '0;
                    if (step_q == SP_FETCH) rdata_q <= m_rdata;
                end
            end
        end
    end

    // outputs
    always_comb begin
        idle    = (state_q == ST_IDLE);
        done    = (state_q == ST_DONE);
        timeout = done & timeout_q;
        rdata   = rdata_q;
        m_req   = 1'b0;
        m_we    = 1'b0;
        m_addr  = '0;
        m_wdata = '0;
        unique case (state_q)
            ST_PAGE: begin
                m_req   = 1'b1;
                m_we    = 1'b1;
                m_addr  = PAGE_ADDR;
                m_wdata = page_word;
            end
            ST_WIN: begin
                m_req   = 1'b1;
                m_we    = acc_we;
                m_addr  = win_off;
                m_wdata = acc_wdata;
            end
            default: begin
                m_req = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/phy_cr_engine_chk.sv
module phy_cr_engine_chk #(
    parameter int DW  = 16,
    parameter int ABW = 12
) (
    input logic           clk,
    input logic           rst_n,
    input logic           idle,
    input logic           done,
    input logic           timeout,
    input logic           m_req,
    input logic           m_we,
    input logic [ABW-1:0] m_addr,
    input logic [DW-1:0]  m_wdata,
    input logic           m_ready
);
    localparam logic [ABW-1:0] PG = ABW'(12'h800);

    p_page_is_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && (m_addr == PG)) |-> m_we);

    p_window_follows_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_ready && (m_addr == PG)) |=> (m_req && (m_addr != PG)));

    p_timeout_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> done);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !m_req);

    p_bus_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ready) |=>
            (m_req && $stable(m_we) && $stable(m_addr) && $stable(m_wdata)));

endmodule

bind phy_cr_engine phy_cr_engine_chk #(.DW(DW), .ABW(ABW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .idle    (idle),
    .done    (done),
    .timeout (timeout),
    .m_req   (m_req),
    .m_we    (m_we),
    .m_addr  (m_addr),
    .m_wdata (m_wdata),
    .m_ready (m_ready)
);

// File: tb/phy_cr_engine_bench.sv
`timescale 1ns/1ps
module phy_cr_engine_bench;
    localparam int DW = 16, ABW = 12, GAPW = 16, MAXP = 4;
    localparam logic [15:0] A_CMD = 16'h80A0, A_ADR = 16'h80A1, A_DAT = 16'h80A2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_start = 1'b0;
    logic [4:0] req_dev = '0;
    logic [15:0] req_addr = '0;
    logic req_write = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic [GAPW-1:0] cfg_poll_gap = '0;
    logic idle, done, timeout, m_req, m_we, m_ready;
    logic [DW-1:0] rdata, m_wdata, m_rdata;
    logic [ABW-1:0] m_addr;

    int checks = 0, fails = 0, cyc = 0;

    always #2 clk = ~clk;

    phy_cr_engine #(.DW(DW), .ABW(ABW), .GAPW(GAPW), .MAX_POLLS(MAXP)) u_phy_cr_engine (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_dev(req_dev),
        .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
        .cfg_poll_gap(cfg_poll_gap), .idle(idle), .done(done), .timeout(timeout),
        .rdata(rdata), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ready(m_ready)
    );

    function automatic logic [15:0] rd_fn(input logic [4:0] d, input logic [15:0] a);
        return (a * 16'd5) ^ {d, 11'h2A5};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- PHY window model ----------------
    logic [11:0] pg;
    logic        fresh;
    int          busy_left, pre_cfg = 0, post_cfg = 0;
    logic [15:0] cr_addr, fetch_val;
    int          lat_cnt, xfer_n, tr_n, proto_err;
    logic [37:0] trace [64];
    logic [15:0] iaddr_c;

    assign iaddr_c = {pg[6:0], m_addr[10:2]};

    always_comb begin
        if (iaddr_c == A_CMD)      m_rdata = {15'h0, busy_left != 0};
        else if (iaddr_c == A_DAT) m_rdata = fetch_val;
        else                       m_rdata = 16'h0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ready <= 1'b0; lat_cnt <= 0; xfer_n <= 0; tr_n <= 0; proto_err <= 0;
            pg <= '0; fresh <= 1'b0; busy_left <= 0; cr_addr <= '0; fetch_val <= '0;
        end else begin
            if (req_start && idle) begin
                tr_n <= 0;
                busy_left <= pre_cfg;
            end
            if (m_req && m_ready) begin
                m_ready <= 1'b0; lat_cnt <= 0; xfer_n <= xfer_n + 1;
                if (m_addr == 12'h800) begin
                    if (!m_we) proto_err <= proto_err + 1;
                    pg <= m_wdata[11:0];
                    fresh <= 1'b1;
                end else begin
                    if (!fresh || m_addr[1:0] != 2'b00 || m_addr[11]) proto_err <= proto_err + 1;
                    fresh <= 1'b0;
                    if (tr_n < 64) trace[tr_n] <= {m_we, pg[11:7], iaddr_c, m_we ? m_wdata : 16'h0};
                    tr_n <= tr_n + 1;
                    if (m_we && iaddr_c == A_CMD && m_wdata[0]) begin
                        busy_left <= post_cfg;
                        if (!m_wdata[1]) fetch_val <= rd_fn(pg[11:7], cr_addr);
                    end
                    if (m_we && iaddr_c == A_ADR) cr_addr <= m_wdata;
                    if (!m_we && iaddr_c == A_CMD && busy_left > 0) busy_left <= busy_left - 1;
                end
            end else if (m_req) begin
                if (lat_cnt >= (xfer_n % 3)) m_ready <= 1'b1;
                else lat_cnt <= lat_cnt + 1;
            end
        end
    end

    // ---------------- gap monitor (R7) ----------------
    int cur_gap = 0, lowrun = 0;
    always @(negedge clk) begin
        if (rst_n && !idle) begin
            if (!m_req && !done) lowrun++;
            else if (m_req && lowrun > 0) begin
                chk(lowrun == cur_gap + 1, "R7", "poll gap cycles", lowrun, cur_gap + 1);
                lowrun = 0;
            end
        end else lowrun = 0;
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            fails++;
            $display("FAIL watchdog (all requirements) actual=%0d expected<190000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // ---------------- request driver ----------------
    logic [37:0] expv [64];
    int exp_n;
    bit exp_to;

    task automatic push(input bit we, input logic [4:0] d, input logic [15:0] a, input logic [15:0] v);
        expv[exp_n] = {we, d, a, we ? v : 16'h0};
        exp_n++;
    endtask

    task automatic push_poll(input logic [4:0] d, input int busy);
        if (busy >= MAXP) begin
            for (int i = 0; i < MAXP; i++) push(1'b0, d, A_CMD, 16'h0);
            exp_to = 1'b1;
        end else begin
            for (int i = 0; i <= busy; i++) push(1'b0, d, A_CMD, 16'h0);
        end
    endtask

    task automatic run_req(input logic [4:0] d, input logic [15:0] a, input bit wr,
                           input logic [15:0] wd, input int pre, input int post,
                           input int gap, input bit poke);
        logic [15:0] exp_rd;
        int w;
        bit tr_ok;
        exp_n = 0; exp_to = 1'b0;
        push_poll(d, pre);
        if (!exp_to) begin
            push(1'b1, d, A_ADR, a);
            if (wr) begin
                push(1'b1, d, A_DAT, wd);
                push(1'b1, d, A_CMD, 16'h0003);
            end else begin
                push(1'b1, d, A_CMD, 16'h0001);
                push_poll(d, post);
                if (!exp_to) push(1'b0, d, A_DAT, 16'h0);
            end
        end
        exp_rd = (wr || exp_to) ? 16'h0 : rd_fn(d, a);

        @(negedge clk);
        pre_cfg = pre; post_cfg = post; cfg_poll_gap = GAPW'(gap); cur_gap = gap;
        req_dev = d; req_addr = a; req_write = wr; req_wdata = wd; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        w = 0;
        while (!done && w < 3000) begin
            if (poke && w == 3) begin
                req_start = 1'b1; req_addr = ~a; req_write = ~wr; req_dev = ~d;
            end else req_start = 1'b0;
            @(negedge clk);
            w++;
        end
        req_start = 1'b0;
        chk(done == 1'b1, "R9", "done seen", done, 1);
        chk(timeout == exp_to, exp_to ? "R8" : "R9", "timeout flag", timeout, exp_to);
        chk(rdata == exp_rd, wr ? "R5/R9" : "R4/R9", "rdata", rdata, exp_rd);
        tr_ok = (tr_n == exp_n);
        for (int i = 0; i < exp_n && tr_ok; i++) begin
            if (trace[i] != expv[i]) begin
                tr_ok = 1'b0;
                $display("FAIL R2/R3/R6 trace step %0d actual=%0h expected=%0h", i, trace[i], expv[i]);
            end
        end
        chk(tr_ok, wr ? "R5" : "R4", "trace length", tr_n, exp_n);
        if (poke) chk(tr_ok && rdata == exp_rd, "R10", "request unaffected by strobe", rdata, exp_rd);
        @(negedge clk);
        chk(!done && idle, "R9", "done one cycle", done, 0);
    endtask

    initial begin
        logic [15:0] addrs [5];
        addrs[0] = 16'h0000; addrs[1] = 16'h01FF; addrs[2] = 16'h0200;
        addrs[3] = 16'hFFFF; addrs[4] = 16'h2002;
        repeat (3) @(negedge clk);
        chk(idle && !done && !timeout && !m_req, "R1", "reset state in reset",
            {idle, done, timeout, m_req}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(idle && !done && !timeout && !m_req, "R1", "reset state after release",
            {idle, done, timeout, m_req}, 4'b1000);

        // sweep devices x boundary addresses x direction (R2 R3 R4 R5 R6 R7)
        for (int d = 0; d < 32; d++)
            for (int k = 0; k < 5; k++)
                for (int wr = 0; wr < 2; wr++)
                    run_req(5'(d), addrs[k] ^ 16'(k == 4 ? d : 0), wr[0],
                            16'hA5C3 ^ 16'(d * 257 + k * 31), (d + k) % 3,
                            (d + wr + k) % 3, (d % 3) * 3, 1'b0);

        // poll limit (R8): pre-phase and post-phase, plus one-short neighbour
        run_req(5'd7, 16'h1234, 1'b0, 16'h0, MAXP, 0, 2, 1'b0);
        run_req(5'd7, 16'h1234, 1'b1, 16'hBEEF, 9, 0, 1, 1'b0);
        run_req(5'd9, 16'h4321, 1'b0, 16'h0, 0, MAXP, 0, 1'b0);
        run_req(5'd9, 16'h4321, 1'b0, 16'h0, MAXP - 1, MAXP - 1, 4, 1'b0);

        // strobe while busy (R10), read and write
        run_req(5'd3, 16'h0A0B, 1'b0, 16'h0, 2, 2, 5, 1'b1);
        run_req(5'd30, 16'hC0DE, 1'b1, 16'h1357, 1, 0, 5, 1'b1);

        chk(proto_err == 0, "R2/R3/R11", "window protocol errors", proto_err, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule